// File: doc/BRIEF.md
# Granularity-Hint Translation Buffer

This block is a fully associative address translation buffer for a demand-paged memory manager. Privileged software fills it one entry at a time and removes entries with invalidation commands. Each entry maps one 8 KB base page, or an aligned group of 8, 64 or 512 base pages. A two-bit hint stored in the entry picks the group size. A larger group leaves more virtual page bits out of the tag compare and passes them straight through to the physical address.

A lookup presents a virtual address and the current address space number. The match is combinational, and the result goes through one register stage. One cycle after the request the block returns a hit flag, a multi-hit flag and the translated physical address. A miss is only flagged. Page-table walks, protection checks and cache interaction are left to other logic. The data-side instance has 64 entries. An instruction-side instance of the same design uses `ENTRIES = 48`.

Top module: `gran_xlate_buf`

## Requirements
- R1: Physical address bits [12:0] of a hit equal virtual address bits [12:0] of the request.
- R2: Hint encoding `hint[1:0]`: 0 → 1 page, 1 → 8 pages, 2 → 64 pages, 3 → 512 pages. The low 0, 3, 6 or 9 virtual page number bits are left out of the tag compare. Those bits of the physical page number are taken from the request address and not from the stored entry.
- R3: An entry hits only when all of these are true:
  - it is valid;
  - its masked page number matches the request;
  - its address space number equals `curAsn`, or its global bit is set.
- R4: `respValid` equals `lookupValid` delayed by one cycle, and the result is reported in that cycle. On a miss, `respHit`, `respMulti` and `respPa` are zero.
- R5: A write loads the entry at a round-robin slot. The slot starts at 0 after reset, advances by one on each write and wraps after `ENTRIES - 1`. The `ENTRIES + 1`-th write after a fill overwrites the oldest entry.
- R6: Flush-all: `invCmd` = 1 invalidates every entry.
- R7: Flush by address space: `invCmd` = 2 invalidates every non-global entry whose address space number equals `invAsn`. Global entries and entries of other spaces are kept.
- R8: Flush single: `invCmd` = 3 invalidates the entries that a lookup of `invVa` with space `invAsn` would hit. Other entries are kept.
- R9: When more than one entry hits, `respMulti` is 1 and the translation comes from the lowest-indexed matching entry.
- R10: Reset clears all entries and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | VA_W | Virtual address to translate |
| curAsn | input | ASN_W | Current address space number |
| wrEn | input | 1 | Load one entry |
| wrVpn | input | VA_W-13 | Virtual page number of new entry |
| wrPpn | input | PA_W-13 | Physical page number of new entry |
| wrHint | input | 2 | Group-size hint of new entry |
| wrAsn | input | ASN_W | Address space number of new entry |
| wrGlobal | input | 1 | Global bit of new entry |
| invCmd | input | 2 | 0 none, 1 all, 2 by space, 3 single address |
| invAsn | input | ASN_W | Space number for commands 2 and 3 |
| invVa | input | VA_W | Address for command 3 |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Translation found |
| respMulti | output | 1 | More than one entry matched |
| respPa | output | PA_W | Translated physical address |

## Verification
The assertions check on every cycle the following:
- response timing relative to the request;
- pass-through of the page offset on a hit;
- zeroed outputs on a miss;
- that multi-hit never appears without a hit;
- that a lookup right after a flush-all misses.

The bench scenarios cover the behaviour that depends on stored contents, since only they set up known tables:
- how much of the address the hint masks and passes through;
- address space and global qualification;
- which entries each selective flush removes;
- round-robin replacement order;
- lowest-index selection on a multi-hit.

// File: rtl/gxb_pkg.sv
package gxb_pkg;
  localparam int PAGE_OFF_W = 13;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_ASN  = 2'd2,
    INV_VA   = 2'd3
  } invCmd_e;

  typedef struct packed {
    logic load;
    logic flushAll;
    logic flushAsn;
    logic flushVa;
  } gxbStrobes_t;
endpackage

// File: rtl/gxb_ctrl.sv
module gxb_ctrl
  import gxb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       invCmd,
  output gxbStrobes_t      strobes,
  output logic [IDX_W-1:0] fillSlot
);
  logic [IDX_W-1:0] fillPtr;

  always_comb begin
    strobes.load     = wrEn;
    strobes.flushAll = (invCmd == INV_ALL);
    strobes.flushAsn = (invCmd == INV_ASN);
    strobes.flushVa  = (invCmd == INV_VA);
  end

  assign fillSlot = fillPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillPtr <= '0;
    end else if (wrEn) begin
      if (fillPtr == IDX_W'(ENTRIES - 1)) fillPtr <= '0;
      else fillPtr <= fillPtr + 1'b1;
    end
  end
endmodule

// File: rtl/gxb_datapath.sv
module gxb_datapath
  import gxb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W = 40,
  parameter int PA_W = 36,
  parameter int ASN_W = 7,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W = VA_W - PAGE_OFF_W,
  localparam int PPN_W = PA_W - PAGE_OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  gxbStrobes_t      strobes,
  input  logic [IDX_W-1:0] fillSlot,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  input  logic [ASN_W-1:0] curAsn,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic [1:0]       wrHint,
  input  logic [ASN_W-1:0] wrAsn,
  input  logic             wrGlobal,
  input  logic [ASN_W-1:0] invAsn,
  input  logic [VA_W-1:0]  invVa,
  output logic             respValid,
  output logic             respHit,
  output logic             respMulti,
  output logic [PA_W-1:0]  respPa
);
  logic [ENTRIES-1:0]  entValid;
  logic [VPN_W-1:0]    entVpn  [ENTRIES];
  logic [PPN_W-1:0]    entPpn  [ENTRIES];
  logic [1:0]          entHint [ENTRIES];
  logic [ASN_W-1:0]    entAsn  [ENTRIES];
  logic [ENTRIES-1:0]  entGlobal;

  logic [ENTRIES-1:0]  lookMatch, invMatch;
  logic [VPN_W-1:0]    lookVpn, invVpn;
  logic                anyHit, multiHit;
  logic [IDX_W-1:0]    selIdx;
  logic [PPN_W-1:0]    selPpnMask, mergedPpn;

  assign lookVpn = lookupVa[VA_W-1:PAGE_OFF_W];
  assign invVpn  = invVa[VA_W-1:PAGE_OFF_W];

  function automatic logic [VPN_W-1:0] vpnKeepMask(input logic [1:0] hint);
    return ~((VPN_W'(1) << (3 * hint)) - VPN_W'(1));
  endfunction

  function automatic logic [PPN_W-1:0] ppnKeepMask(input logic [1:0] hint);
    return ~((PPN_W'(1) << (3 * hint)) - PPN_W'(1));
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    logic lookTag, invTag;
    assign lookTag = (((entVpn[i] ^ lookVpn) & vpnKeepMask(entHint[i])) == '0);
    assign invTag  = (((entVpn[i] ^ invVpn) & vpnKeepMask(entHint[i])) == '0);
    assign lookMatch[i] = entValid[i] && lookTag && (entGlobal[i] || entAsn[i] == curAsn);
    assign invMatch[i]  = entValid[i] && invTag && (entGlobal[i] || entAsn[i] == invAsn);
  end

  // lowest-index priority and multi-hit detection
  always_comb begin
    anyHit   = 1'b0;
    multiHit = 1'b0;
    selIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookMatch[i]) selIdx = IDX_W'(i);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) begin
        if (anyHit) multiHit = 1'b1;
        anyHit = 1'b1;
      end
    end
  end

  assign selPpnMask = ppnKeepMask(entHint[selIdx]);
  assign mergedPpn  = (entPpn[selIdx] & selPpnMask) | (PPN_W'(lookVpn) & ~selPpnMask);

  // valid bits: invalidation acts on old contents, a same-cycle load wins its slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.load && fillSlot == IDX_W'(i)) entValid[i] <= 1'b1;
        else if (strobes.flushAll) entValid[i] <= 1'b0;
        else if (strobes.flushAsn && !entGlobal[i] && entAsn[i] == invAsn) entValid[i] <= 1'b0;
        else if (strobes.flushVa && invMatch[i]) entValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      entVpn[fillSlot]    <= wrVpn;
      entPpn[fillSlot]    <= wrPpn;
      entHint[fillSlot]   <= wrHint;
      entAsn[fillSlot]    <= wrAsn;
      entGlobal[fillSlot] <= wrGlobal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMulti <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && anyHit;
      respMulti <= lookupValid && multiHit;
      respPa    <= (lookupValid && anyHit) ? {mergedPpn, lookupVa[PAGE_OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/gran_xlate_buf.sv
module gran_xlate_buf
  import gxb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W = 40,
  parameter int PA_W = 36,
  parameter int ASN_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lookupValid,
  input  logic [VA_W-1:0]            lookupVa,
  input  logic [ASN_W-1:0]           curAsn,
  input  logic                       wrEn,
  input  logic [VA_W-PAGE_OFF_W-1:0] wrVpn,
  input  logic [PA_W-PAGE_OFF_W-1:0] wrPpn,
  input  logic [1:0]                 wrHint,
  input  logic [ASN_W-1:0]           wrAsn,
  input  logic                       wrGlobal,
  input  logic [1:0]                 invCmd,
  input  logic [ASN_W-1:0]           invAsn,
  input  logic [VA_W-1:0]            invVa,
  output logic                       respValid,
  output logic                       respHit,
  output logic                       respMulti,
  output logic [PA_W-1:0]            respPa
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  gxbStrobes_t      strobes;
  logic [IDX_W-1:0] fillSlot;

  gxb_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .invCmd(invCmd),
    .strobes(strobes), .fillSlot(fillSlot)
  );

  gxb_datapath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASN_W(ASN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillSlot(fillSlot),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .curAsn(curAsn),
    .wrVpn(wrVpn), .wrPpn(wrPpn), .wrHint(wrHint), .wrAsn(wrAsn), .wrGlobal(wrGlobal),
    .invAsn(invAsn), .invVa(invVa),
    .respValid(respValid), .respHit(respHit), .respMulti(respMulti), .respPa(respPa)
  );
endmodule

// File: rtl/gxb_checker.sv
module gxb_checker #(
  parameter int VA_W = 40,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic [VA_W-1:0] lookupVa,
  input logic            wrEn,
  input logic [1:0]      invCmd,
  input logic            respValid,
  input logic            respHit,
  input logic            respMulti,
  input logic [PA_W-1:0] respPa
);
  assert_resp_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    respValid == $past(lookupValid));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (respPa == '0 && !respMulti));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respPa[12:0] == $past(lookupVa[12:0]));

  assert_multi_has_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    respMulti |-> respHit);

  assert_flush_all_misses_R6: assert property (@(posedge clk) disable iff (!rstN)
    (invCmd == 2'd1 && !wrEn) ##1 (lookupValid && !wrEn) |=> !respHit);

  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R10: assert (!respValid && !respHit && !respMulti && respPa == '0);
  end
endmodule

bind gran_xlate_buf gxb_checker #(.VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .wrEn(wrEn), .invCmd(invCmd), .respValid(respValid), .respHit(respHit),
  .respMulti(respMulti), .respPa(respPa)
);

// File: tb/gran_xlate_buf_tb.sv
module gran_xlate_buf_tb_top;
  localparam int ENTRIES = 64;
  localparam int VA_W = 40;
  localparam int PA_W = 36;
  localparam int ASN_W = 7;
  localparam int VPN_W = VA_W - 13;
  localparam int PPN_W = PA_W - 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [VA_W-1:0] lookupVa = '0;
  logic [ASN_W-1:0] curAsn = '0;
  logic wrEn = 1'b0;
  logic [VPN_W-1:0] wrVpn = '0;
  logic [PPN_W-1:0] wrPpn = '0;
  logic [1:0] wrHint = '0;
  logic [ASN_W-1:0] wrAsn = '0;
  logic wrGlobal = 1'b0;
  logic [1:0] invCmd = '0;
  logic [ASN_W-1:0] invAsn = '0;
  logic [VA_W-1:0] invVa = '0;
  logic respValid, respHit, respMulti;
  logic [PA_W-1:0] respPa;

  int testsRun = 0;
  int testsFailed = 0;
  int wrCount = 0;
  logic gotValid, gotHit, gotMulti;
  logic [PA_W-1:0] gotPa;

  always #10 clk = ~clk;

  gran_xlate_buf #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASN_W(ASN_W)) dut_i (.*);

  function automatic logic [VA_W-1:0] mkVa(input logic [VPN_W-1:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input logic [ASN_W-1:0] asn);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = va; curAsn = asn;
    @(negedge clk);
    lookupValid = 1'b0;
    gotValid = respValid; gotHit = respHit; gotMulti = respMulti; gotPa = respPa;
  endtask

  task automatic expectHit(input logic [VA_W-1:0] va, input logic [ASN_W-1:0] asn,
                           input logic [PPN_W-1:0] ppn, input string req);
    lookup(va, asn);
    check(gotHit === 1'b1, req, "hit", 64'(gotHit), 64'd1);
    check(gotPa === {ppn, va[12:0]}, req, "pa", 64'(gotPa), 64'({ppn, va[12:0]}));
  endtask

  task automatic expectMiss(input logic [VA_W-1:0] va, input logic [ASN_W-1:0] asn, input string req);
    lookup(va, asn);
    check(gotHit === 1'b0 && gotPa === '0, req, "miss", 64'(gotPa), 64'd0);
  endtask

  task automatic writeEntry(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                            input logic [1:0] hint, input logic [ASN_W-1:0] asn, input logic g);
    @(negedge clk);
    wrEn = 1'b1; wrVpn = vpn; wrPpn = ppn; wrHint = hint; wrAsn = asn; wrGlobal = g;
    @(negedge clk);
    wrEn = 1'b0;
    wrCount++;
  endtask

  task automatic invalidate(input logic [1:0] cmd, input logic [ASN_W-1:0] asn, input logic [VA_W-1:0] va);
    @(negedge clk);
    invCmd = cmd; invAsn = asn; invVa = va;
    @(negedge clk);
    invCmd = 2'd0;
  endtask

  task automatic t_reset();
    check(respValid === 1'b0 && respHit === 1'b0 && respPa === '0, "R10", "outputs after reset", 64'(respPa), 64'd0);
    expectMiss(mkVa(27'h123, 13'h0), 7'd0, "R10");
    check(gotValid === 1'b1, "R4", "respValid after request", 64'(gotValid), 64'd1);
  endtask

  task automatic t_basic();
    writeEntry(27'h123, 23'h456, 2'd0, 7'd5, 1'b0);
    expectHit(mkVa(27'h123, 13'h1abc), 7'd5, 23'h456, "R1");
    expectMiss(mkVa(27'h124, 13'h1abc), 7'd5, "R4");
    @(negedge clk);
    check(respValid === 1'b0, "R4", "respValid idle", 64'(respValid), 64'd0);
  endtask

  task automatic t_hint();
    invalidate(2'd1, 7'd0, '0);
    writeEntry(27'h1000, 23'h2000, 2'd2, 7'd1, 1'b0);
    expectHit(mkVa(27'h1025, 13'h7), 7'd1, 23'h2025, "R2");
    expectMiss(mkVa(27'h1040, 13'h7), 7'd1, "R2");
    writeEntry(27'h40000, 23'h00e00, 2'd3, 7'd1, 1'b0);
    expectHit(mkVa(27'h401ff, 13'h1fff), 7'd1, 23'h00fff, "R2");
    writeEntry(27'h800, 23'h3007, 2'd1, 7'd1, 1'b0);
    expectHit(mkVa(27'h805, 13'h10), 7'd1, 23'h3005, "R2");
  endtask

  task automatic t_asn();
    invalidate(2'd1, 7'd0, '0);
    writeEntry(27'h55, 23'h155, 2'd0, 7'd3, 1'b0);
    writeEntry(27'h66, 23'h166, 2'd0, 7'd3, 1'b1);
    writeEntry(27'h77, 23'h177, 2'd0, 7'd4, 1'b0);
    expectMiss(mkVa(27'h55, 13'h1), 7'd4, "R3");
    expectHit(mkVa(27'h55, 13'h1), 7'd3, 23'h155, "R3");
    expectHit(mkVa(27'h66, 13'h2), 7'd9, 23'h166, "R3");
  endtask

  task automatic t_flush_asn();
    invalidate(2'd2, 7'd3, '0);
    expectMiss(mkVa(27'h55, 13'h1), 7'd3, "R7");
    expectHit(mkVa(27'h66, 13'h2), 7'd9, 23'h166, "R7");
    expectHit(mkVa(27'h77, 13'h3), 7'd4, 23'h177, "R7");
  endtask

  task automatic t_flush_va();
    writeEntry(27'h90, 23'h190, 2'd0, 7'd2, 1'b0);
    writeEntry(27'h91, 23'h191, 2'd0, 7'd2, 1'b0);
    invalidate(2'd3, 7'd2, mkVa(27'h90, 13'h0));
    expectMiss(mkVa(27'h90, 13'h4), 7'd2, "R8");
    expectHit(mkVa(27'h91, 13'h4), 7'd2, 23'h191, "R8");
  endtask

  task automatic t_flush_all();
    invalidate(2'd1, 7'd0, '0);
    expectMiss(mkVa(27'h91, 13'h4), 7'd2, "R6");
    expectMiss(mkVa(27'h66, 13'h2), 7'd9, "R6");
  endtask

  task automatic t_multi();
    int slotA, slotB;
    slotA = wrCount % ENTRIES;
    slotB = (wrCount + 1) % ENTRIES;
    writeEntry(27'h200, 23'h111, 2'd0, 7'd6, 1'b0);
    writeEntry(27'h200, 23'h222, 2'd1, 7'd6, 1'b0);
    lookup(mkVa(27'h200, 13'h5), 7'd6);
    check(gotHit === 1'b1 && gotMulti === 1'b1, "R9", "multi flag", 64'(gotMulti), 64'd1);
    check(gotPa === {(slotA < slotB) ? 23'h111 : 23'h220, 13'h5}, "R9", "lowest index pa",
          64'(gotPa), 64'({(slotA < slotB) ? 23'h111 : 23'h220, 13'h5}));
    lookup(mkVa(27'h201, 13'h5), 7'd6);
    check(gotMulti === 1'b0, "R9", "single match no multi", 64'(gotMulti), 64'd0);
    check(gotPa === {23'h221, 13'h5}, "R2", "group pa", 64'(gotPa), 64'({23'h221, 13'h5}));
  endtask

  task automatic t_round_robin();
    invalidate(2'd1, 7'd0, '0);
    for (int i = 0; i < ENTRIES; i++) writeEntry(27'h1000 + 27'(i), 23'h4000 + 23'(i), 2'd0, 7'd8, 1'b0);
    expectHit(mkVa(27'h1000, 13'h0), 7'd8, 23'h4000, "R5");
    expectHit(mkVa(27'h1000 + 27'(ENTRIES - 1), 13'h0), 7'd8, 23'h4000 + 23'(ENTRIES - 1), "R5");
    writeEntry(27'h5000, 23'h6000, 2'd0, 7'd8, 1'b0);
    expectMiss(mkVa(27'h1000, 13'h0), 7'd8, "R5");
    expectHit(mkVa(27'h1001, 13'h0), 7'd8, 23'h4001, "R5");
    expectHit(mkVa(27'h5000, 13'h0), 7'd8, 23'h6000, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_hint();
    t_asn();
    t_flush_asn();
    t_flush_va();
    t_flush_all();
    t_multi();
    t_round_robin();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule